// File: doc/BRIEF.md
# Lockable Two-Way Instruction Cache Controller

This block keeps the tag, status and word store of a two-way set-associative instruction cache with 128 sets of two columns, each block holding four 32-bit instructions (256 blocks, 1K instructions). A fetch presents an address and a user/supervisor mode flag. The block answers with a hit and the instruction in the same cycle, or with a miss. On a miss it starts a refill of one chosen column and takes the four words of the block from the memory side.

Configuration inputs can lock column 0 alone or both columns. A locked column keeps its valid blocks, but an invalid block in it may still be filled, and that block then carries a lock mark. A one-cycle invalidate command clears every block. It is ignored while any lock is set, unless the cache is also disabled. While the cache is disabled, lookups neither hit nor miss, and a debug register pair can read and write any block's tag-status word directly.

Top module: `icache_lock_ctrl`

## Requirements
- R1: After reset every block is invalid, no lookup hits, `refill_req` is 0, and every tag-status word reads as valid=0, lock=0.
- R2: A lookup hits only when the cache is enabled and a valid block in set `lk_addr[10:4]` holds tag `lk_addr[31:11]` and the same mode bit as `lk_super`. It then returns the word selected by `lk_addr[3:2]` in the same cycle. Any other tag or mode misses.
- R3: An enabled lookup that misses drives `lk_miss` in the same cycle. If a victim exists and no refill is running, `refill_req` rises on the next cycle with `refill_addr` set to the block-aligned miss address. It stays high until the fourth `fill_valid` word. The block becomes valid only after that word is written.
- R4: With `cfg_lock`=00 the victim is column 0 if it is invalid, otherwise column 1 if it is invalid, otherwise the least recently used column of the set. A hit or a fill makes the other column least recently used.
- R5: `inv_cmd` with `cfg_lock`=00 clears the valid bit of every block, user and supervisor, in one cycle.
- R6: With `cfg_lock`=01 a valid column 0 block is never replaced. An invalid column 0 is filled and marked locked. Every other refill of the set goes to column 1.
- R7: With `cfg_lock`=10 or 11 a valid block is never replaced. An invalid block is filled and marked locked. A miss on a set whose two blocks are both valid raises no refill.
- R8: While `cfg_lock` is non-zero, `inv_cmd` has no effect unless `cfg_disable` is 1.
- R9: While `cfg_disable` is 1, `lk_hit` and `lk_miss` stay 0, no refill starts, and the stored blocks are kept.
- R10: The interface register holds function select in bits [29:28] (01 = tag access), write in bit [24], column in bit [11] and set in bits [10:4]. While the cache is disabled and the function is 01, `dbg_rdata` shows the selected tag-status word, and a data write with the write bit set stores it (writing zero invalidates). In every other case `dbg_rdata` is 0 and data writes are ignored.
- R11: A tag-status word holds the tag in [31:11], lock in [2], valid in [1] and the supervisor flag in [0]. Fetches of one address in the two modes occupy separate blocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_disable | input | 1 | Cache disable |
| cfg_lock | input | 2 | Lock setting: 00 none, 01 column 0, 1x both |
| inv_cmd | input | 1 | Invalidate-all command |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Lookup byte address |
| lk_super | input | 1 | Lookup is a supervisor-mode fetch |
| lk_hit | output | 1 | Lookup hit |
| lk_miss | output | 1 | Lookup miss |
| lk_data | output | 32 | Instruction word on a hit |
| refill_req | output | 1 | Refill in progress, words wanted |
| refill_addr | output | 32 | Block-aligned refill address |
| fill_valid | input | 1 | Refill word strobe |
| fill_data | input | 32 | Refill word, in ascending order |
| dbg_ifc_we | input | 1 | Load the interface register |
| dbg_ifc_wdata | input | 32 | Interface register value |
| dbg_dat_we | input | 1 | Write the data register |
| dbg_dat_wdata | input | 32 | Tag-status word to store |
| dbg_rdata | output | 32 | Tag-status word read back |

## Verification
The hardest case to reach is a set whose column 0 is valid and locked while column 1 keeps being replaced. The least recently used bit must point at column 0 at that moment, or the test proves nothing. The bench gets there by filling both columns under the column-0 lock, then hitting the column 1 block so that column 0 becomes the LRU choice, then forcing another miss. Block placement is read back through the debug port with the cache disabled.

// File: rtl/icache_pkg.sv
package icache_pkg;

   typedef enum logic [1:0] {
      LOCK_NONE = 2'b00,
      LOCK_COL0 = 2'b01,
      LOCK_BOTH = 2'b10
   } lock_mode_e;

   localparam logic [1:0] FSEL_TAG = 2'b01;

   function automatic lock_mode_e decode_lock(input logic [1:0] raw);
      case (raw)
         2'b00:   return LOCK_NONE;
         2'b01:   return LOCK_COL0;
         default: return LOCK_BOTH;
      endcase
   endfunction

endpackage

// File: rtl/icache_tag_store.sv
module icache_tag_store #(
   parameter int SETS  = 128,
   parameter int TAG_W = 21,
   localparam int IDX_W = $clog2(SETS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   inv_all,
   input  logic                   wr_en,
   input  logic [IDX_W-1:0]       wr_set,
   input  logic                   wr_col,
   input  logic [TAG_W-1:0]       wr_tag,
   input  logic                   wr_valid,
   input  logic                   wr_super,
   input  logic                   wr_lock,
   input  logic                   lru_en,
   input  logic [IDX_W-1:0]       lru_set,
   input  logic                   lru_used,
   input  logic [IDX_W-1:0]       rd_set,
   output logic [1:0][TAG_W-1:0]  rd_tag,
   output logic [1:0]             rd_valid,
   output logic [1:0]             rd_super,
   output logic [1:0]             rd_lock,
   output logic                   rd_lru
);

   logic [SETS-1:0] lru_q;

   for (genvar c = 0; c < 2; c++) begin : g_col
      logic [TAG_W-1:0] tag_q [SETS];
      logic [SETS-1:0]  valid_q;
      logic [SETS-1:0]  super_q;
      logic [SETS-1:0]  lock_q;
      logic             sel;

      assign sel = wr_en && (wr_col == 1'(c));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_q <= '0;
            super_q <= '0;
            lock_q  <= '0;
         end else begin
            if (inv_all) begin
               valid_q <= '0;
               lock_q  <= '0;
            end
            if (sel) begin
               valid_q[wr_set] <= wr_valid;
               super_q[wr_set] <= wr_super;
               lock_q[wr_set]  <= wr_lock;
            end
         end
      end

      always_ff @(posedge clk) begin
         if (sel) tag_q[wr_set] <= wr_tag;
      end

      assign rd_tag[c]   = tag_q[rd_set];
      assign rd_valid[c] = valid_q[rd_set];
      assign rd_super[c] = super_q[rd_set];
      assign rd_lock[c]  = lock_q[rd_set];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lru_q <= '0;
      else if (lru_en) lru_q[lru_set] <= ~lru_used;
   end

   assign rd_lru = lru_q[rd_set];

endmodule

// File: rtl/icache_victim_sel.sv
module icache_victim_sel
   import icache_pkg::*;
(
   input  lock_mode_e  mode,
   input  logic [1:0]  valid,
   input  logic        lru,
   output logic        vic_ok,
   output logic        vic_col,
   output logic        vic_lock
);

   always_comb begin
      vic_ok   = 1'b1;
      vic_col  = 1'b0;
      vic_lock = 1'b0;
      case (mode)
         LOCK_NONE: vic_col = !valid[0] ? 1'b0 : (!valid[1] ? 1'b1 : lru);
         LOCK_COL0: begin
            vic_col  = valid[0];
            vic_lock = !valid[0];
         end
         default: begin
            vic_lock = 1'b1;
            vic_col  = valid[0];
            vic_ok   = ~&valid;
         end
      endcase
   end

endmodule

// File: rtl/icache_data_store.sv
module icache_data_store #(
   parameter int SETS   = 128,
   parameter int WORDS  = 4,
   parameter int DATA_W = 32,
   localparam int IDX_W  = $clog2(SETS),
   localparam int WSEL_W = $clog2(WORDS),
   localparam int DEPTH  = SETS * WORDS
) (
   input  logic                    clk,
   input  logic                    wr_en,
   input  logic [IDX_W-1:0]        wr_set,
   input  logic                    wr_col,
   input  logic [WSEL_W-1:0]       wr_word,
   input  logic [DATA_W-1:0]       wr_data,
   input  logic [IDX_W-1:0]        rd_set,
   input  logic [WSEL_W-1:0]       rd_word,
   output logic [1:0][DATA_W-1:0]  rd_data
);

   for (genvar c = 0; c < 2; c++) begin : g_col
      logic [DATA_W-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
         if (wr_en && (wr_col == 1'(c))) mem[{wr_set, wr_word}] <= wr_data;
      end

      assign rd_data[c] = mem[{rd_set, rd_word}];
   end

endmodule

// File: rtl/icache_lock_ctrl.sv
module icache_lock_ctrl
   import icache_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int SETS   = 128,
   parameter int WORDS  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_disable,
   input  logic [1:0]        cfg_lock,
   input  logic              inv_cmd,
   input  logic              lk_valid,
   input  logic [ADDR_W-1:0] lk_addr,
   input  logic              lk_super,
   output logic              lk_hit,
   output logic              lk_miss,
   output logic [DATA_W-1:0] lk_data,
   output logic              refill_req,
   output logic [ADDR_W-1:0] refill_addr,
   input  logic              fill_valid,
   input  logic [DATA_W-1:0] fill_data,
   input  logic              dbg_ifc_we,
   input  logic [DATA_W-1:0] dbg_ifc_wdata,
   input  logic              dbg_dat_we,
   input  logic [DATA_W-1:0] dbg_dat_wdata,
   output logic [DATA_W-1:0] dbg_rdata
);

   localparam int IDX_W   = $clog2(SETS);
   localparam int WSEL_W  = $clog2(WORDS);
   localparam int OFF_W   = WSEL_W + 2;
   localparam int TAG_W   = ADDR_W - IDX_W - OFF_W;
   localparam int COL_BIT = OFF_W + IDX_W;
   localparam int PAD_W   = DATA_W - TAG_W - 3;

   if (SETS < 2 || (1 << IDX_W) != SETS) begin : g_bad_sets
      $error("SETS must be a power of two of at least 2");
   end
   if (WORDS < 2 || (1 << WSEL_W) != WORDS) begin : g_bad_words
      $error("WORDS must be a power of two of at least 2");
   end
   if (PAD_W < 1 || DATA_W < 30) begin : g_bad_word_fmt
      $error("DATA_W too narrow for the tag-status word");
   end
   if (COL_BIT >= 24) begin : g_bad_ifc_fmt
      $error("debug address fields overlap the control bits");
   end

   lock_mode_e lock_mode;
   logic       locked;
   assign lock_mode = decode_lock(cfg_lock);
   assign locked    = (lock_mode != LOCK_NONE);

   logic [IDX_W-1:0]  lk_set;
   logic [WSEL_W-1:0] lk_word;
   logic [TAG_W-1:0]  lk_tag;
   assign lk_set  = lk_addr[OFF_W +: IDX_W];
   assign lk_word = lk_addr[2 +: WSEL_W];
   assign lk_tag  = lk_addr[ADDR_W-1 -: TAG_W];

   // debug interface register
   logic [DATA_W-1:0] dbg_ifc_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          dbg_ifc_q <= '0;
      else if (dbg_ifc_we) dbg_ifc_q <= dbg_ifc_wdata;
   end

   logic [IDX_W-1:0] dbg_set;
   logic             dbg_col;
   logic             dbg_tag_sel;
   logic             dbg_wr;
   assign dbg_set     = dbg_ifc_q[OFF_W +: IDX_W];
   assign dbg_col     = dbg_ifc_q[COL_BIT];
   assign dbg_tag_sel = cfg_disable && (dbg_ifc_q[29:28] == FSEL_TAG);
   assign dbg_wr      = dbg_dat_we && dbg_tag_sel && dbg_ifc_q[24];

   // tag store read side
   logic [IDX_W-1:0]       rd_set;
   logic [1:0][TAG_W-1:0]  rd_tag;
   logic [1:0]             rd_valid, rd_super, rd_lock;
   logic                   rd_lru;
   assign rd_set = cfg_disable ? dbg_set : lk_set;

   // fill state
   logic              busy_q;
   logic [IDX_W-1:0]  fill_set_q;
   logic              fill_col_q;
   logic [TAG_W-1:0]  fill_tag_q;
   logic              fill_super_q;
   logic              fill_lock_q;
   logic [WSEL_W-1:0] word_cnt_q;

   // hit detection per column
   logic [1:0] way_hit;
   for (genvar c = 0; c < 2; c++) begin : g_cmp
      assign way_hit[c] = rd_valid[c] && (rd_tag[c] == lk_tag) && (rd_super[c] == lk_super);
   end

   logic hit_col;
   logic lk_act;
   assign lk_act  = lk_valid && !cfg_disable;
   assign hit_col = way_hit[1];
   assign lk_hit  = lk_act && (|way_hit);
   assign lk_miss = lk_act && !(|way_hit);

   logic vic_ok, vic_col, vic_lock;
   icache_victim_sel u_vic (
      .mode     (lock_mode),
      .valid    (rd_valid),
      .lru      (rd_lru),
      .vic_ok   (vic_ok),
      .vic_col  (vic_col),
      .vic_lock (vic_lock)
   );

   logic start_fill, fill_last, inv_all;
   assign start_fill = lk_miss && !busy_q && vic_ok;
   assign fill_last  = busy_q && fill_valid && (word_cnt_q == WSEL_W'(WORDS - 1));
   assign inv_all    = inv_cmd && (!locked || cfg_disable);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q       <= 1'b0;
         fill_set_q   <= '0;
         fill_col_q   <= 1'b0;
         fill_tag_q   <= '0;
         fill_super_q <= 1'b0;
         fill_lock_q  <= 1'b0;
         word_cnt_q   <= '0;
      end else if (start_fill) begin
         busy_q       <= 1'b1;
         fill_set_q   <= lk_set;
         fill_col_q   <= vic_col;
         fill_tag_q   <= lk_tag;
         fill_super_q <= lk_super;
         fill_lock_q  <= vic_lock;
         word_cnt_q   <= '0;
      end else if (busy_q && fill_valid) begin
         word_cnt_q <= word_cnt_q + 1'b1;
         if (fill_last) busy_q <= 1'b0;
      end
   end

   // single tag write port: fill completion, victim clear, debug write
   logic              tw_en, tw_col, tw_valid, tw_super, tw_lock;
   logic [IDX_W-1:0]  tw_set;
   logic [TAG_W-1:0]  tw_tag;
   always_comb begin
      tw_en    = 1'b0;
      tw_set   = lk_set;
      tw_col   = vic_col;
      tw_tag   = lk_tag;
      tw_valid = 1'b0;
      tw_super = lk_super;
      tw_lock  = 1'b0;
      if (fill_last) begin
         tw_en    = 1'b1;
         tw_set   = fill_set_q;
         tw_col   = fill_col_q;
         tw_tag   = fill_tag_q;
         tw_valid = 1'b1;
         tw_super = fill_super_q;
         tw_lock  = fill_lock_q;
      end else if (start_fill) begin
         tw_en = 1'b1;
      end else if (dbg_wr) begin
         tw_en    = 1'b1;
         tw_set   = dbg_set;
         tw_col   = dbg_col;
         tw_tag   = dbg_dat_wdata[DATA_W-1 -: TAG_W];
         tw_lock  = dbg_dat_wdata[2];
         tw_valid = dbg_dat_wdata[1];
         tw_super = dbg_dat_wdata[0];
      end
   end

   logic             lru_en, lru_used;
   logic [IDX_W-1:0] lru_set;
   assign lru_en   = fill_last || lk_hit;
   assign lru_set  = fill_last ? fill_set_q : lk_set;
   assign lru_used = fill_last ? fill_col_q : hit_col;

   icache_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
      .clk      (clk),
      .rst_n    (rst_n),
      .inv_all  (inv_all),
      .wr_en    (tw_en),
      .wr_set   (tw_set),
      .wr_col   (tw_col),
      .wr_tag   (tw_tag),
      .wr_valid (tw_valid),
      .wr_super (tw_super),
      .wr_lock  (tw_lock),
      .lru_en   (lru_en),
      .lru_set  (lru_set),
      .lru_used (lru_used),
      .rd_set   (rd_set),
      .rd_tag   (rd_tag),
      .rd_valid (rd_valid),
      .rd_super (rd_super),
      .rd_lock  (rd_lock),
      .rd_lru   (rd_lru)
   );

   logic [1:0][DATA_W-1:0] rd_data;
   icache_data_store #(.SETS(SETS), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
      .clk     (clk),
      .wr_en   (busy_q && fill_valid),
      .wr_set  (fill_set_q),
      .wr_col  (fill_col_q),
      .wr_word (word_cnt_q),
      .wr_data (fill_data),
      .rd_set  (lk_set),
      .rd_word (lk_word),
      .rd_data (rd_data)
   );

   assign lk_data     = rd_data[hit_col];
   assign refill_req  = busy_q;
   assign refill_addr = {fill_tag_q, fill_set_q, {OFF_W{1'b0}}};
   assign dbg_rdata   = dbg_tag_sel ?
                        {rd_tag[dbg_col], {PAD_W{1'b0}}, rd_lock[dbg_col],
                         rd_valid[dbg_col], rd_super[dbg_col]} : '0;

   logic unused_bits;
   assign unused_bits = ^{lk_addr[1:0], dbg_ifc_q, dbg_dat_wdata[DATA_W-TAG_W-1:3]};

endmodule

// File: rtl/icache_lock_chk.sv
module icache_lock_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_disable,
   input logic [1:0]        cfg_lock,
   input logic              inv_cmd,
   input logic              lk_hit,
   input logic              lk_miss,
   input logic              fill_valid,
   input logic              refill_req,
   input logic [DATA_W-1:0] dbg_rdata
);

   AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(lk_hit && lk_miss)); // R2

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (refill_req && !fill_valid) |=> refill_req); // R3

   AST_REQ_FROM_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(refill_req) |-> $past(lk_miss)); // R3

   AST_INV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_cmd && cfg_lock == 2'b00 && !refill_req) |=> !lk_hit); // R5

   AST_DIS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_disable |-> (!lk_hit && !lk_miss)); // R9

   AST_NO_START_DIS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(refill_req) |-> !$past(cfg_disable)); // R9

   AST_DBG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_disable |-> (dbg_rdata == '0)); // R10

endmodule

bind icache_lock_ctrl icache_lock_chk #(.DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_disable (cfg_disable),
   .cfg_lock    (cfg_lock),
   .inv_cmd     (inv_cmd),
   .lk_hit      (lk_hit),
   .lk_miss     (lk_miss),
   .fill_valid  (fill_valid),
   .refill_req  (refill_req),
   .dbg_rdata   (dbg_rdata)
);

// File: tb/tb_icache_lock_ctrl.sv
module tb_icache_lock_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_disable = 1'b0;
   logic [1:0]  cfg_lock = 2'b00;
   logic        inv_cmd = 1'b0;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_addr = '0;
   logic        lk_super = 1'b0;
   logic        lk_hit, lk_miss, refill_req;
   logic [31:0] lk_data, refill_addr, dbg_rdata;
   logic        fill_valid = 1'b0;
   logic [31:0] fill_data = '0;
   logic        dbg_ifc_we = 1'b0;
   logic [31:0] dbg_ifc_wdata = '0;
   logic        dbg_dat_we = 1'b0;
   logic [31:0] dbg_dat_wdata = '0;

   int tests = 0;
   int fails = 0;

   always #5 clk = ~clk;

   icache_lock_ctrl dut (
      .clk(clk), .rst_n(rst_n), .cfg_disable(cfg_disable), .cfg_lock(cfg_lock),
      .inv_cmd(inv_cmd), .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_super(lk_super),
      .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_data(lk_data), .refill_req(refill_req),
      .refill_addr(refill_addr), .fill_valid(fill_valid), .fill_data(fill_data),
      .dbg_ifc_we(dbg_ifc_we), .dbg_ifc_wdata(dbg_ifc_wdata), .dbg_dat_we(dbg_dat_we),
      .dbg_dat_wdata(dbg_dat_wdata), .dbg_rdata(dbg_rdata)
   );

   function automatic logic [31:0] mk(input logic [20:0] tag, input logic [6:0] set,
                                      input logic [1:0] word);
      return {tag, set, word, 2'b00};
   endfunction

   function automatic logic [31:0] pat(input logic [31:0] addr, input int w);
      return {addr[31:4], 2'(w), 2'b00} ^ 32'h5A5A_0000;
   endfunction

   function automatic logic [31:0] tagword(input logic [20:0] tag, input logic lock,
                                           input logic valid, input logic sup);
      return {tag, 8'h00, lock, valid, sup};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   // lookup without letting a clock edge see it
   task automatic probe(input logic [31:0] addr, input logic sup,
                        output logic hit, output logic miss, output logic [31:0] data);
      lk_addr = addr; lk_super = sup; lk_valid = 1'b1;
      #1;
      hit = lk_hit; miss = lk_miss; data = lk_data;
      lk_valid = 1'b0;
      #1;
   endtask

   task automatic access(input logic [31:0] addr, input logic sup);
      lk_addr = addr; lk_super = sup; lk_valid = 1'b1;
      tick();
      lk_valid = 1'b0;
   endtask

   task automatic feed(input logic [31:0] addr, input int first, input int last);
      for (int w = first; w <= last; w++) begin
         fill_valid = 1'b1;
         fill_data  = pat(addr, w);
         tick();
      end
      fill_valid = 1'b0;
   endtask

   task automatic fetch_fill(input logic [31:0] addr, input logic sup);
      access(addr, sup);
      feed(addr, 0, 3);
   endtask

   task automatic dbg_ifc(input logic [1:0] fsel, input logic wr, input logic col,
                          input logic [6:0] set);
      logic [31:0] v;
      v = '0; v[29:28] = fsel; v[24] = wr; v[11] = col; v[10:4] = set;
      dbg_ifc_we = 1'b1; dbg_ifc_wdata = v;
      tick();
      dbg_ifc_we = 1'b0;
   endtask

   task automatic dbg_read(input logic col, input logic [6:0] set, output logic [31:0] word);
      dbg_ifc(2'b01, 1'b0, col, set);
      #1 word = dbg_rdata;
   endtask

   task automatic dbg_write(input logic col, input logic [6:0] set, input logic [31:0] word);
      dbg_ifc(2'b01, 1'b1, col, set);
      dbg_dat_we = 1'b1; dbg_dat_wdata = word;
      tick();
      dbg_dat_we = 1'b0;
   endtask

   task automatic t_reset();
      logic h, m; logic [31:0] d, w;
      chk("R1 refill_req", 32'(refill_req), 32'd0);
      probe(mk(21'h0, 7'd0, 2'd0), 1'b0, h, m, d);
      chk("R1 no hit", 32'(h), 32'd0);
      cfg_disable = 1'b1;
      dbg_read(1'b0, 7'd0, w);   chk("R1 col0 set0 word", w & 32'h7, 32'd0);
      dbg_read(1'b1, 7'd127, w); chk("R1 col1 set127 word", w & 32'h7, 32'd0);
      cfg_disable = 1'b0;
   endtask

   task automatic t_fill_hit();
      logic h, m; logic [31:0] d, a;
      a = mk(21'h01234, 7'd5, 2'd0);
      lk_addr = a; lk_super = 1'b0; lk_valid = 1'b1;
      #1 chk("R3 miss flag", 32'(lk_miss), 32'd1);
      tick();
      lk_valid = 1'b0;
      chk("R3 refill_req rises", 32'(refill_req), 32'd1);
      chk("R3 refill_addr", refill_addr, a);
      feed(a, 0, 2);
      chk("R3 req held before last word", 32'(refill_req), 32'd1);
      probe(a, 1'b0, h, m, d);
      chk("R3 not valid before last word", 32'(h), 32'd0);
      feed(a, 3, 3);
      chk("R3 req drops", 32'(refill_req), 32'd0);
      probe(mk(21'h01234, 7'd5, 2'd2), 1'b0, h, m, d);
      chk("R2 hit", 32'(h), 32'd1);
      chk("R2 data word2", d, pat(a, 2));
      probe(mk(21'h01235, 7'd5, 2'd0), 1'b0, h, m, d);
      chk("R2 other tag misses", 32'(h), 32'd0);
   endtask

   task automatic t_mode_lru();
      logic h, m; logic [31:0] d, w, a, b, c;
      a = mk(21'h01234, 7'd5, 2'd0);
      b = mk(21'h00777, 7'd5, 2'd0);
      c = mk(21'h00888, 7'd5, 2'd0);
      probe(a, 1'b1, h, m, d);
      chk("R11 super fetch misses user block", 32'(h), 32'd0);
      fetch_fill(a, 1'b1);
      probe(a, 1'b1, h, m, d); chk("R11 super hit", 32'(h), 32'd1);
      probe(a, 1'b0, h, m, d); chk("R11 user still hits", 32'(h), 32'd1);
      cfg_disable = 1'b1;
      dbg_read(1'b0, 7'd5, w); chk("R11 col0 user word", w, tagword(21'h01234, 0, 1, 0));
      dbg_read(1'b1, 7'd5, w); chk("R4 R11 col1 took super", w, tagword(21'h01234, 0, 1, 1));
      cfg_disable = 1'b0;
      access(a, 1'b0);          // col0 used, col1 becomes LRU
      fetch_fill(b, 1'b0);
      access(b, 1'b0);          // col1 used, col0 becomes LRU
      fetch_fill(c, 1'b0);
      cfg_disable = 1'b1;
      dbg_read(1'b1, 7'd5, w); chk("R4 LRU chose col1", w, tagword(21'h00777, 0, 1, 0));
      dbg_read(1'b0, 7'd5, w); chk("R4 LRU chose col0", w, tagword(21'h00888, 0, 1, 0));
      cfg_disable = 1'b0;
   endtask

   task automatic t_inv();
      logic h, m; logic [31:0] d, w, e;
      e = mk(21'h00042, 7'd6, 2'd1);
      fetch_fill(e, 1'b1);
      inv_cmd = 1'b1; tick(); inv_cmd = 1'b0;
      probe(mk(21'h00888, 7'd5, 2'd0), 1'b0, h, m, d); chk("R5 user block gone", 32'(h), 32'd0);
      probe(mk(21'h00777, 7'd5, 2'd0), 1'b0, h, m, d); chk("R5 col1 block gone", 32'(h), 32'd0);
      probe(e, 1'b1, h, m, d); chk("R5 super block gone", 32'(h), 32'd0);
      cfg_disable = 1'b1;
      dbg_read(1'b0, 7'd6, w); chk("R5 valid bit clear", w & 32'h2, 32'd0);
      cfg_disable = 1'b0;
   endtask

   task automatic t_lock_col0();
      logic h, m; logic [31:0] d, w;
      cfg_lock = 2'b01;
      fetch_fill(mk(21'h00100, 7'd9, 2'd0), 1'b0);
      fetch_fill(mk(21'h00200, 7'd9, 2'd0), 1'b0);
      access(mk(21'h00200, 7'd9, 2'd0), 1'b0);   // LRU now points at col0
      fetch_fill(mk(21'h00300, 7'd9, 2'd0), 1'b0);
      cfg_disable = 1'b1;
      dbg_read(1'b0, 7'd9, w); chk("R6 col0 kept and locked", w, tagword(21'h00100, 1, 1, 0));
      dbg_read(1'b1, 7'd9, w); chk("R6 refill went to col1", w, tagword(21'h00300, 0, 1, 0));
      cfg_disable = 1'b0;
      probe(mk(21'h00100, 7'd9, 2'd3), 1'b0, h, m, d);
      chk("R6 locked block hits", 32'(h), 32'd1);
   endtask

   task automatic t_lock_both();
      logic h, m; logic [31:0] d, w;
      cfg_lock = 2'b10;
      fetch_fill(mk(21'h00400, 7'd11, 2'd0), 1'b0);
      fetch_fill(mk(21'h00500, 7'd11, 2'd0), 1'b0);
      lk_addr = mk(21'h00600, 7'd11, 2'd0); lk_super = 1'b0; lk_valid = 1'b1;
      #1 chk("R7 miss flagged", 32'(lk_miss), 32'd1);
      tick();
      lk_valid = 1'b0;
      chk("R7 no refill when both locked", 32'(refill_req), 32'd0);
      probe(mk(21'h00400, 7'd11, 2'd0), 1'b0, h, m, d); chk("R7 col0 kept", 32'(h), 32'd1);
      probe(mk(21'h00500, 7'd11, 2'd0), 1'b0, h, m, d); chk("R7 col1 kept", 32'(h), 32'd1);
      cfg_disable = 1'b1;
      dbg_read(1'b1, 7'd11, w); chk("R7 col1 lock mark", w, tagword(21'h00500, 1, 1, 0));
      cfg_disable = 1'b0;
   endtask

   task automatic t_inv_locked();
      logic h, m; logic [31:0] d;
      inv_cmd = 1'b1; tick(); inv_cmd = 1'b0;
      probe(mk(21'h00400, 7'd11, 2'd0), 1'b0, h, m, d);
      chk("R8 inv ignored, both locked", 32'(h), 32'd1);
      cfg_lock = 2'b01;
      inv_cmd = 1'b1; tick(); inv_cmd = 1'b0;
      probe(mk(21'h00100, 7'd9, 2'd0), 1'b0, h, m, d);
      chk("R8 inv ignored, col0 locked", 32'(h), 32'd1);
      cfg_disable = 1'b1;
      inv_cmd = 1'b1; tick(); inv_cmd = 1'b0;
      cfg_disable = 1'b0;
      probe(mk(21'h00400, 7'd11, 2'd0), 1'b0, h, m, d);
      chk("R8 inv applies when disabled", 32'(h), 32'd0);
      probe(mk(21'h00100, 7'd9, 2'd0), 1'b0, h, m, d);
      chk("R8 col0 block cleared too", 32'(h), 32'd0);
      cfg_lock = 2'b00;
   endtask

   task automatic t_disabled();
      logic h, m; logic [31:0] d, a;
      a = mk(21'h01234, 7'd5, 2'd1);
      fetch_fill(a, 1'b0);
      cfg_disable = 1'b1;
      lk_addr = a; lk_super = 1'b0; lk_valid = 1'b1;
      #1;
      chk("R9 no hit when disabled", 32'(lk_hit), 32'd0);
      chk("R9 no miss when disabled", 32'(lk_miss), 32'd0);
      lk_addr = mk(21'h00999, 7'd5, 2'd0);
      tick();
      lk_valid = 1'b0;
      chk("R9 no refill when disabled", 32'(refill_req), 32'd0);
      cfg_disable = 1'b0;
      probe(a, 1'b0, h, m, d);
      chk("R9 block kept", 32'(h), 32'd1);
   endtask

   task automatic t_dbg();
      logic h, m; logic [31:0] d, w;
      cfg_disable = 1'b1;
      dbg_write(1'b1, 7'd20, tagword(21'h00ABC, 0, 1, 1));
      #1 chk("R10 readback", dbg_rdata, tagword(21'h00ABC, 0, 1, 1));
      dbg_ifc(2'b10, 1'b0, 1'b1, 7'd20);
      #1 chk("R10 other fsel reads zero", dbg_rdata, 32'd0);
      cfg_disable = 1'b0;
      probe(mk(21'h00ABC, 7'd20, 2'd0), 1'b1, h, m, d);
      chk("R10 written tag hits", 32'(h), 32'd1);
      dbg_ifc(2'b01, 1'b0, 1'b1, 7'd20);
      #1 chk("R10 enabled reads zero", dbg_rdata, 32'd0);
      dbg_ifc(2'b01, 1'b1, 1'b0, 7'd21);
      dbg_dat_we = 1'b1; dbg_dat_wdata = tagword(21'h00DEF, 0, 1, 0);
      tick();
      dbg_dat_we = 1'b0;
      probe(mk(21'h00DEF, 7'd21, 2'd0), 1'b0, h, m, d);
      chk("R10 enabled write ignored", 32'(h), 32'd0);
      cfg_disable = 1'b1;
      dbg_write(1'b1, 7'd20, 32'd0);
      cfg_disable = 1'b0;
      probe(mk(21'h00ABC, 7'd20, 2'd0), 1'b1, h, m, d);
      chk("R10 zero write invalidates", 32'(h), 32'd0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      tests++; fails++;
      $display("FAIL R1 watchdog act=timeout exp=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_fill_hit();
      t_mode_lru();
      t_inv();
      t_lock_col0();
      t_lock_both();
      t_inv_locked();
      t_disabled();
      t_dbg();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule